// File: doc/BRIEF.md
# Column Token Readout Controller

This block sits at the foot of a pixel column and drains the hit buffers of its 45 pixels over a shared digital bus. A pass position walks up the column. Each cycle the controller grants a one-hot token to the lowest pixel at or above that position whose buffer reports data. The granted pixel places its oldest coarse/fine time pair on the shared bus. The controller tags the pair with the pixel address, stores it in a small output FIFO and pulses a pop strobe back to that pixel.

When the pass runs out of pixels with data, the position returns to pixel 0. A pixel that has just been read is not served again until the next pass, so one busy pixel cannot starve the others. The FIFO hands words to a downstream multi-column merger through a valid/ready handshake. When the FIFO is full, the token stays parked on its pixel until an entry drains.

Top module: `col_token_rdo`

## Requirements
- R1: After reset, with every pixel empty, no token is granted, no pop strobe is issued and out_valid_o is low; the first search starts at pixel 0.
- R2: pix_tok_o is one-hot or zero. Its single bit marks the lowest-numbered pixel whose not-empty flag is high, counting from the current pass position upward. Pixels below that position and empty pixels are skipped.
- R3: A pop strobe goes to the token holder, and only in a cycle in which the FIFO is not full. At most one word is captured per clock.
- R4: Each captured word is laid out as {address[23:18], coarse[17:8], fine[7:0]}. The address is the binary index (0..44) of the token holder, and the time fields are the bus values in the capture cycle.
- R5: After a pixel is read, the next search starts at the pixel above it, so a pixel is read at most once per pass. After pixel 44 is read, the next search starts at pixel 0.
- R6: If no pixel at or above the pass position has data, the cycle is idle: no token and no pop. The next search starts at pixel 0.
- R7: While the FIFO is full, no pop occurs and the token stays on the same pixel until a FIFO entry is removed.
- R8: The output FIFO holds 8 words and delivers them first-in first-out. out_valid_o is high exactly while it holds a word, and a handshake occurs when out_valid_o and out_ready_i are both high at a clock edge.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o and out_data_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_nempty_i | input | 45 | Per-pixel buffer not-empty flags |
| pix_tok_o | output | 45 | One-hot token to the pixels |
| pix_rd_o | output | 45 | One-hot pop strobe to the token holder |
| bus_coarse_i | input | 10 | Coarse time driven by the token holder |
| bus_fine_i | input | 8 | Fine time driven by the token holder |
| out_valid_o | output | 1 | Output word available |
| out_ready_i | input | 1 | Merger accepts the word |
| out_data_o | output | 24 | Tagged output word |

## Verification
The bench targets the pass boundaries:
- A hit on pixel 44 followed by a restart at 0. A design that searched past the top, or skipped the idle cycle, would grant the wrong pixel or grant it a cycle early.
- A pixel holding four words next to a sparsely hit pixel. A controller that stayed on the deep pixel would read it back to back and starve its neighbour.
- A full FIFO with the merger stalled. This catches a token that wanders away, and a pop of a word that never reaches the FIFO.
- A long random phase with a toggling ready. This exposes corrupted or reordered words and data that changes under stall.

// File: rtl/col_rdo_pkg.sv
package col_rdo_pkg;
  localparam int NPIX       = 45;
  localparam int COARSE_W   = 10;
  localparam int FINE_W     = 8;
  localparam int FIFO_DEPTH = 8;
  localparam int ADDR_W     = $clog2(NPIX);
  localparam int WORD_W     = ADDR_W + COARSE_W + FINE_W;
endpackage

// File: rtl/col_prio_find.sv
module col_prio_find #(
  parameter int N  = 45,
  parameter int AW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [AW-1:0] start_i,
  output logic          hit_o,
  output logic [AW-1:0] idx_o
);
  // lowest set bit at or above start_i
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && (i >= int'(start_i))) begin
        hit_o = 1'b1;
        idx_o = AW'(i);
      end
    end
  end
endmodule

// File: rtl/col_token_seq.sv
module col_token_seq #(
  parameter int N  = 45,
  parameter int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  nempty_i,
  input  logic          space_i,
  output logic [N-1:0]  tok_o,
  output logic [N-1:0]  rd_o,
  output logic          wr_o,
  output logic [AW-1:0] idx_o,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          hit;
  logic [AW-1:0] idx;

  col_prio_find #(.N(N), .AW(AW)) u_find (
    .req_i  (nempty_i),
    .start_i(ptr_q),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  for (genvar g = 0; g < N; g++) begin : g_tok
    assign tok_o[g] = hit && (idx == AW'(g));
    assign rd_o[g]  = tok_o[g] && space_i;
  end

  assign wr_o  = hit && space_i;
  assign idx_o = idx;
  assign ptr_o = ptr_q;

  always_comb begin
    if (hit && space_i)  ptr_d = (idx == LAST) ? '0 : idx + 1'b1;
    else if (hit)        ptr_d = idx;  // park on the holder
    else                 ptr_d = '0;   // pass exhausted
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end
endmodule

// File: rtl/col_out_fifo.sv
module col_out_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [W-1:0]    wdata_i,
  output logic            full_o,
  output logic            valid_o,
  input  logic            ready_i,
  output logic [W-1:0]    rdata_o,
  output logic [CNTW-1:0] cnt_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wp_q, rp_q;
  logic [CNTW-1:0] cnt_q;
  logic            do_wr, do_rd;

  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = valid_o && ready_i;
  assign rdata_o = mem[rp_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= (wp_q == PLAST) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == PLAST) ? '0 : rp_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/col_token_rdo.sv
module col_token_rdo
  import col_rdo_pkg::*;
#(
  parameter int NPIX_P   = NPIX,
  parameter int COARSE_P = COARSE_W,
  parameter int FINE_P   = FINE_W,
  parameter int DEPTH_P  = FIFO_DEPTH,
  parameter int AW_P     = $clog2(NPIX_P),
  parameter int WW_P     = AW_P + COARSE_P + FINE_P
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPIX_P-1:0]   pix_nempty_i,
  output logic [NPIX_P-1:0]   pix_tok_o,
  output logic [NPIX_P-1:0]   pix_rd_o,
  input  logic [COARSE_P-1:0] bus_coarse_i,
  input  logic [FINE_P-1:0]   bus_fine_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [WW_P-1:0]     out_data_o
);
  localparam int CNTW = $clog2(DEPTH_P + 1);

  logic            fifo_full, cap_wr;
  logic [AW_P-1:0] tok_idx, pass_ptr;
  logic [CNTW-1:0] fifo_cnt;
  logic [WW_P-1:0] cap_word;

  col_token_seq #(.N(NPIX_P), .AW(AW_P)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nempty_i(pix_nempty_i),
    .space_i (!fifo_full),
    .tok_o   (pix_tok_o),
    .rd_o    (pix_rd_o),
    .wr_o    (cap_wr),
    .idx_o   (tok_idx),
    .ptr_o   (pass_ptr)
  );

  assign cap_word = {tok_idx, bus_coarse_i, bus_fine_i};

  col_out_fifo #(.W(WW_P), .DEPTH(DEPTH_P), .CNTW(CNTW)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cap_wr),
    .wdata_i(cap_word),
    .full_o (fifo_full),
    .valid_o(out_valid_o),
    .ready_i(out_ready_i),
    .rdata_o(out_data_o),
    .cnt_o  (fifo_cnt)
  );
endmodule

// File: rtl/col_token_rdo_chk.sv
module col_token_rdo_chk #(
  parameter int NPIX_P  = 45,
  parameter int DEPTH_P = 8,
  parameter int AW_P    = 6,
  parameter int WW_P    = 24,
  parameter int CNTW    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NPIX_P-1:0] pix_nempty_i,
  input logic [NPIX_P-1:0] pix_tok_o,
  input logic [NPIX_P-1:0] pix_rd_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [WW_P-1:0]   out_data_o,
  input logic [AW_P-1:0]   tok_idx,
  input logic [AW_P-1:0]   pass_ptr,
  input logic [CNTW-1:0]   fifo_cnt
);
  p_tok_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pix_tok_o));

  p_tok_on_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_tok_o & ~pix_nempty_i) == '0);

  p_rd_holder_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_rd_o & ~pix_tok_o) == '0);

  p_no_rd_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == CNTW'(DEPTH_P)) |-> (pix_rd_o == '0));

  p_park_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pix_tok_o != '0) && (pix_rd_o == '0)) |=> (pass_ptr == $past(tok_idx)));

  p_advance_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_rd_o != '0) |=>
      (pass_ptr == (($past(tok_idx) == AW_P'(NPIX_P - 1)) ? '0 : $past(tok_idx) + 1'b1)));

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_tok_o == '0) |=> (pass_ptr == '0));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNTW'(DEPTH_P));

  p_out_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

bind col_token_rdo col_token_rdo_chk #(
  .NPIX_P(NPIX_P), .DEPTH_P(DEPTH_P), .AW_P(AW_P), .WW_P(WW_P), .CNTW(CNTW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_nempty_i(pix_nempty_i),
  .pix_tok_o   (pix_tok_o),
  .pix_rd_o    (pix_rd_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .tok_idx     (tok_idx),
  .pass_ptr    (pass_ptr),
  .fifo_cnt    (fifo_cnt)
);

// File: tb/col_token_rdo_tb_top.sv
module col_token_rdo_tb_top;
  localparam int NP  = 45;
  localparam int CW  = 10;
  localparam int FW  = 8;
  localparam int DEP = 8;
  localparam int BD  = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [NP-1:0] nempty, tok, rd;
  logic [CW-1:0] bus_c;
  logic [FW-1:0] bus_f;
  logic          out_valid, out_ready;
  logic [23:0]   out_data;

  logic [CW-1:0] pc [NP][BD];
  logic [FW-1:0] pf [NP][BD];
  int            pcnt [NP];

  int            mptr;
  logic [23:0]   mq [$];
  int            checks = 0, fails = 0;
  string         cur_req = "R2";

  col_token_rdo dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pix_nempty_i(nempty),
    .pix_tok_o   (tok),
    .pix_rd_o    (rd),
    .bus_coarse_i(bus_c),
    .bus_fine_i  (bus_f),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data)
  );

  always_comb begin
    for (int p = 0; p < NP; p++) nempty[p] = (pcnt[p] > 0);
  end

  always_comb begin
    bus_c = '0;
    bus_f = '0;
    for (int p = 0; p < NP; p++) begin
      if (tok[p]) begin
        bus_c = pc[p][0];
        bus_f = pf[p][0];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_hit(input int p, input logic [CW-1:0] c, input logic [FW-1:0] f);
    if (pcnt[p] < BD) begin
      pc[p][pcnt[p]] = c;
      pf[p][pcnt[p]] = f;
      pcnt[p]++;
    end
  endtask

  task automatic pix_pop(input int p);
    for (int k = 0; k < BD - 1; k++) begin
      pc[p][k] = pc[p][k+1];
      pf[p][k] = pf[p][k+1];
    end
    pcnt[p]--;
  endtask

  task automatic step();
    bit          hit, space, wr, deq;
    int          idx;
    logic [NP-1:0] etok, erd;
    logic [23:0] word;
    @(negedge clk);
    #1;
    hit = 1'b0;
    idx = 0;
    for (int i = mptr; i < NP; i++) begin
      if (pcnt[i] > 0) begin
        hit = 1'b1;
        idx = i;
        break;
      end
    end
    space = (mq.size() < DEP);
    etok  = '0;
    if (hit) etok[idx] = 1'b1;
    erd   = space ? etok : '0;
    chk(tok === etok, cur_req, "token", 64'(tok), 64'(etok));
    chk(rd === erd, (hit && !space) ? "R7" : "R3", "pop strobe", 64'(rd), 64'(erd));
    chk(out_valid === (mq.size() > 0), "R8", "out_valid", 64'(out_valid), 64'(mq.size() > 0));
    if (mq.size() > 0) chk(out_data === mq[0], "R4", "out_data", 64'(out_data), 64'(mq[0]));
    wr   = hit && space;
    deq  = (mq.size() > 0) && out_ready;
    word = wr ? {6'(idx), pc[idx][0], pf[idx][0]} : '0;
    if (wr)       mptr = (idx == NP - 1) ? 0 : idx + 1;
    else if (hit) mptr = idx;
    else          mptr = 0;
    @(posedge clk);
    #1;
    if (deq) void'(mq.pop_front());
    if (wr) begin
      mq.push_back(word);
      pix_pop(idx);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      pcnt[p] = 0;
      for (int k = 0; k < BD; k++) begin
        pc[p][k] = '0;
        pf[p][k] = '0;
      end
    end
    rst_n     = 1'b0;
    out_ready = 1'b0;
    mptr      = 0;
    repeat (2) @(posedge clk);
    #1;
    chk(tok === '0, "R1", "reset token", 64'(tok), 0);
    chk(rd === '0, "R1", "reset pop", 64'(rd), 0);
    chk(out_valid === 1'b0, "R1", "reset valid", 64'(out_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R2 R4: sparse hits, skipping empties
    cur_req   = "R2";
    out_ready = 1'b1;
    add_hit(3, 10'h155, 8'h11);
    add_hit(17, 10'h2aa, 8'h22);
    add_hit(44, 10'h3ff, 8'hff);
    repeat (12) step();

    // R5: deep pixel shares passes with a shallow one
    cur_req = "R5";
    for (int k = 0; k < 4; k++) add_hit(5, 10'(k + 1), 8'(k + 8'h50));
    add_hit(40, 10'h0aa, 8'h40);
    add_hit(40, 10'h0bb, 8'h41);
    repeat (20) step();

    // R6: wrap after pixel 44 and empty-pass restart
    cur_req = "R6";
    add_hit(44, 10'h101, 8'h01);
    step();
    add_hit(0, 10'h102, 8'h02);
    add_hit(44, 10'h103, 8'h03);
    repeat (8) step();

    // R7: stalled merger fills the FIFO, token parks
    cur_req   = "R7";
    out_ready = 1'b0;
    for (int p = 2; p < 14; p++) add_hit(p, 10'(p * 7), 8'(p));
    repeat (16) step();
    cur_req   = "R8";
    out_ready = 1'b1;
    repeat (20) step();

    // R9: random traffic with toggling ready
    cur_req = "R2";
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 3) == 0) add_hit($urandom % NP, 10'($urandom), 8'($urandom));
      out_ready = (($urandom % 3) != 0);
      step();
    end
    out_ready = 1'b1;
    repeat (250) step();
    chk(out_valid === 1'b0, "R8", "drained", 64'(out_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule